// File: doc/BRIEF.md
# Vendor Control Request Register Decoder

This block sits between an already-parsed control-transfer front end and a UART serial engine. Each request arrives as a setup record (request type, request code, payload length), followed, for host-to-device requests, by its payload bytes. Both arrive on separate valid/ready channels. The block checks every request against a fixed map of vendor request codes.

For a host-to-device request it collects the payload and updates one of the configuration registers it owns: line control, modem control, baud divisor, or transmit CTS gating. For a device-to-host request it returns one byte, either the line control register or the modem status byte supplied by the serial engine.

Every request ends with a one-cycle response pulse that carries an error flag and any read-back byte. A successful write also raises a matching one-cycle write strobe. The serial engine uses these strobes to reload its settings.

Top module: `vreq_decoder`

## Requirements
- R1: After a synchronous reset, the registers hold these values: line control 0x00, modem control 0x00, CTS gating 0, divisor 12. The divisor value is the reference rate 115200 divided by 9600. Also after reset, `setup_ready` is 1, `rsp_valid` is 0 and no strobe is set.
- R2: A request with type 0x40, code 7 and length 1 stores its single payload byte in `lcr_q`. It answers with no error, and `reg_wr_stb` bit 0 pulses in the same cycle as `rsp_valid`.
- R3: A request with type 0xC0, code 6 and length 1 accepts no payload. In the cycle after the setup handshake it answers with `rsp_data` equal to the current line control value and no error.
- R4: A request with type 0x40, code 10 and length 1 stores its payload byte in `mcr_q`, and `reg_wr_stb` bit 1 pulses.
- R5: A request with type 0xC0, code 2 and length 1 answers with the `msr_in` value sampled at the setup handshake. It pulses `msr_rd_stb` together with `rsp_valid`.
- R6: A request with type 0x40, code 5 and length 4 loads `div_q` little-endian: the first byte goes to bits 7:0 and the last byte to bits 31:24. `div_q` stays unchanged until the fourth byte is accepted, and `reg_wr_stb` bit 2 then pulses.
- R7: A request with type 0x40, code 12 and length 1 works as follows. Payload 0x00 clears `cts_gate_q`, so transmission proceeds without CTS. Payload 0x01 sets it, so transmission waits for CTS. In both cases `reg_wr_stb` bit 3 pulses. Any other payload value is answered with an error and leaves the gating unchanged.
- R8: A request with type 0x40, code 11 and length 1 consumes its byte and answers with no error. It changes no register and raises no strobe.
- R9: A request is rejected if its type is other than 0x40 or 0xC0, if its code is not in the map for that type, or if its length differs from the size the code expects. A rejected request is answered with an error in the cycle after the setup handshake. It accepts no payload bytes and changes no register.
- R10: Exactly one response pulse follows each request: one cycle after the handshake that completes it. At most one `reg_wr_stb` bit is set at a time, and only together with an error-free response. `setup_ready` is low while a payload is being collected.
- R11: Payload bytes count only on a `wdat_valid`/`wdat_ready` handshake. Idle cycles between bytes do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setup_valid | input | 1 | Setup record valid |
| setup_ready | output | 1 | Block can take a setup record |
| setup_type | input | 8 | Request type byte |
| setup_code | input | 8 | Request code |
| setup_len | input | 16 | Payload length in bytes |
| wdat_valid | input | 1 | Payload byte valid |
| wdat_ready | output | 1 | Block can take a payload byte |
| wdat_byte | input | 8 | Payload byte |
| msr_in | input | 8 | Modem status byte from the serial engine |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Request was rejected |
| rsp_data | output | 8 | Read-back byte (0 for writes) |
| msr_rd_stb | output | 1 | Modem status was read (the engine may clear its change flags) |
| reg_wr_stb | output | 4 | Write strobes: bit 0 line control, 1 modem control, 2 divisor, 3 CTS gating |
| lcr_q | output | 8 | Line control register |
| mcr_q | output | 8 | Modem control register |
| div_q | output | 32 | Baud divisor |
| cts_gate_q | output | 1 | 1 = transmitter waits for CTS |

## Verification
A wrong byte count or a lost request kind shows up in several ways. The response pulse arrives early or late compared with the last payload handshake. `setup_ready` stays low, so the next request stalls. The divisor picks up bytes in the wrong lanes. A broken decode shows up one cycle after the setup handshake: an error flag appears where none is expected, or a strobe bit appears on the wrong register. The bench also samples the divisor between the third and fourth bytes, which exposes any early commit.

// File: rtl/vreq_pkg.sv
package vreq_pkg;
  localparam logic [7:0] RT_HOST_WR = 8'h40;
  localparam logic [7:0] RT_HOST_RD = 8'hC0;

  localparam logic [7:0] OP_MSR_GET = 8'd2;
  localparam logic [7:0] OP_DIV_SET = 8'd5;
  localparam logic [7:0] OP_LCR_GET = 8'd6;
  localparam logic [7:0] OP_LCR_SET = 8'd7;
  localparam logic [7:0] OP_MCR_SET = 8'd10;
  localparam logic [7:0] OP_AUX_SET = 8'd11;
  localparam logic [7:0] OP_CTS_SET = 8'd12;

  localparam int STB_LCR = 0;
  localparam int STB_MCR = 1;
  localparam int STB_DIV = 2;
  localparam int STB_CTS = 3;
  localparam int STB_N   = 4;

  typedef enum logic [2:0] {
    K_BAD, K_DIV, K_LCR_W, K_MCR_W, K_CTS, K_NOP, K_LCR_R, K_MSR_R
  } req_kind_e;

  function automatic logic kind_has_payload(req_kind_e k);
    return (k == K_DIV) || (k == K_LCR_W) || (k == K_MCR_W) ||
           (k == K_CTS) || (k == K_NOP);
  endfunction
endpackage

// File: rtl/vreq_classify.sv
module vreq_classify
  import vreq_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int PAY_BYTES = 4,
  localparam int CNT_W    = $clog2(PAY_BYTES + 1)
) (
  input  logic [7:0]       rtype,
  input  logic [7:0]       code,
  input  logic [LEN_W-1:0] len,
  output req_kind_e        kind,
  output logic [CNT_W-1:0] need
);
  req_kind_e kind_c;

  always_comb begin
    kind_c = K_BAD;
    need   = CNT_W'(1);
    if (rtype == RT_HOST_WR) begin
      case (code)
        OP_DIV_SET: begin kind_c = K_DIV; need = CNT_W'(PAY_BYTES); end
        OP_LCR_SET: kind_c = K_LCR_W;
        OP_MCR_SET: kind_c = K_MCR_W;
        OP_CTS_SET: kind_c = K_CTS;
        OP_AUX_SET: kind_c = K_NOP;
        default:    kind_c = K_BAD;
      endcase
    end else if (rtype == RT_HOST_RD) begin
      case (code)
        OP_LCR_GET: kind_c = K_LCR_R;
        OP_MSR_GET: kind_c = K_MSR_R;
        default:    kind_c = K_BAD;
      endcase
    end
    kind = (len == LEN_W'(need)) ? kind_c : K_BAD;
  end
endmodule

// File: rtl/vreq_seq.sv
module vreq_seq
  import vreq_pkg::*;
#(
  parameter int PAY_BYTES = 4,
  localparam int CNT_W    = $clog2(PAY_BYTES + 1),
  localparam int PAY_W    = PAY_BYTES * 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             setup_valid,
  output logic             setup_ready,
  input  req_kind_e        kind_in,
  input  logic [CNT_W-1:0] need_in,
  input  logic             wdat_valid,
  output logic             wdat_ready,
  input  logic [7:0]       wdat_byte,
  output logic             ev_valid,
  output req_kind_e        ev_kind,
  output logic [PAY_W-1:0] ev_data
);
  typedef enum logic {S_IDLE, S_DATA} st_e;

  st_e              st_q;
  req_kind_e        kind_q;
  logic [CNT_W-1:0] need_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PAY_W-1:0] stage_q;
  logic [PAY_W-1:0] merged;
  logic             setup_fire;
  logic             byte_fire;
  logic             last_byte;

  assign setup_ready = (st_q == S_IDLE);
  assign wdat_ready  = (st_q == S_DATA);
  assign setup_fire  = setup_valid && setup_ready;
  assign byte_fire   = wdat_valid && wdat_ready;
  assign last_byte   = byte_fire && (cnt_q == CNT_W'(need_q - 1'b1));

  always_comb begin
    merged = stage_q;
    merged[int'(cnt_q) * 8 +: 8] = wdat_byte;
    ev_valid = (setup_fire && !kind_has_payload(kind_in)) || last_byte;
    ev_kind  = (st_q == S_IDLE) ? kind_in : kind_q;
    ev_data  = (st_q == S_IDLE) ? '0 : merged;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= S_IDLE;
      kind_q  <= K_BAD;
      need_q  <= CNT_W'(1);
      cnt_q   <= '0;
      stage_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (setup_fire && kind_has_payload(kind_in)) begin
          st_q    <= S_DATA;
          kind_q  <= kind_in;
          need_q  <= need_in;
          cnt_q   <= '0;
          stage_q <= '0;
        end
        default: if (byte_fire) begin
          stage_q <= merged;
          cnt_q   <= cnt_q + 1'b1;
          if (last_byte) st_q <= S_IDLE;
        end
      endcase
    end
  end

  p_cnt_bound_r11: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_DATA) |-> (cnt_q < need_q));
  p_div_full_r6: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_kind == K_DIV) |-> (cnt_q == CNT_W'(PAY_BYTES - 1)));
  p_bad_no_data_r9: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_DATA) |-> (kind_q != K_BAD));
endmodule

// File: rtl/vreq_regs.sv
module vreq_regs
  import vreq_pkg::*;
#(
  parameter int PAY_BYTES  = 4,
  parameter int REF_RATE   = 115200,
  parameter int RESET_BAUD = 9600,
  localparam int PAY_W     = PAY_BYTES * 8,
  localparam int DIV_RESET = REF_RATE / RESET_BAUD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_valid,
  input  req_kind_e        ev_kind,
  input  logic [PAY_W-1:0] ev_data,
  input  logic [7:0]       msr_in,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [7:0]       rsp_data,
  output logic             msr_rd_stb,
  output logic [STB_N-1:0] wr_stb_q,
  output logic [7:0]       lcr_q,
  output logic [7:0]       mcr_q,
  output logic [PAY_W-1:0] div_q,
  output logic             cts_gate_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_data   <= '0;
      msr_rd_stb <= 1'b0;
      wr_stb_q   <= '0;
      lcr_q      <= '0;
      mcr_q      <= '0;
      div_q      <= PAY_W'(DIV_RESET);
      cts_gate_q <= 1'b0;
    end else begin
      rsp_valid  <= ev_valid;
      wr_stb_q   <= '0;
      msr_rd_stb <= 1'b0;
      if (ev_valid) begin
        rsp_err  <= 1'b0;
        rsp_data <= '0;
        case (ev_kind)
          K_DIV:   begin div_q <= ev_data;      wr_stb_q[STB_DIV] <= 1'b1; end
          K_LCR_W: begin lcr_q <= ev_data[7:0]; wr_stb_q[STB_LCR] <= 1'b1; end
          K_MCR_W: begin mcr_q <= ev_data[7:0]; wr_stb_q[STB_MCR] <= 1'b1; end
          K_CTS: begin
            if (ev_data[7:1] == 7'd0) begin
              cts_gate_q        <= ev_data[0];
              wr_stb_q[STB_CTS] <= 1'b1;
            end else begin
              rsp_err <= 1'b1;
            end
          end
          K_NOP:   ;
          K_LCR_R: rsp_data <= lcr_q;
          K_MSR_R: begin rsp_data <= msr_in; msr_rd_stb <= 1'b1; end
          default: rsp_err <= 1'b1;
        endcase
      end
    end
  end

  p_stb_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_stb_q));
  p_stb_needs_ok_r10: assert property (@(posedge clk) disable iff (rst)
    (|wr_stb_q) |-> (rsp_valid && !rsp_err));
  p_lcr_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_stb_q[STB_LCR] |=> $stable(lcr_q) || wr_stb_q[STB_LCR]);
  p_div_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_stb_q[STB_DIV] |=> $stable(div_q) || wr_stb_q[STB_DIV]);
  p_cts_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !wr_stb_q[STB_CTS] |=> $stable(cts_gate_q) || wr_stb_q[STB_CTS]);
  p_msr_with_rsp_r5: assert property (@(posedge clk) disable iff (rst)
    msr_rd_stb |-> (rsp_valid && !rsp_err));
endmodule

// File: rtl/vreq_decoder.sv
module vreq_decoder
  import vreq_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int PAY_BYTES  = 4,
  parameter int REF_RATE   = 115200,
  parameter int RESET_BAUD = 9600,
  localparam int CNT_W     = $clog2(PAY_BYTES + 1),
  localparam int PAY_W     = PAY_BYTES * 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             setup_valid,
  output logic             setup_ready,
  input  logic [7:0]       setup_type,
  input  logic [7:0]       setup_code,
  input  logic [LEN_W-1:0] setup_len,
  input  logic             wdat_valid,
  output logic             wdat_ready,
  input  logic [7:0]       wdat_byte,
  input  logic [7:0]       msr_in,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [7:0]       rsp_data,
  output logic             msr_rd_stb,
  output logic [STB_N-1:0] reg_wr_stb,
  output logic [7:0]       lcr_q,
  output logic [7:0]       mcr_q,
  output logic [PAY_W-1:0] div_q,
  output logic             cts_gate_q
);
  req_kind_e        kind_w;
  logic [CNT_W-1:0] need_w;
  logic             ev_valid;
  req_kind_e        ev_kind;
  logic [PAY_W-1:0] ev_data;

  vreq_classify #(.LEN_W(LEN_W), .PAY_BYTES(PAY_BYTES)) u_classify (
    .rtype(setup_type), .code(setup_code), .len(setup_len),
    .kind(kind_w), .need(need_w)
  );

  vreq_seq #(.PAY_BYTES(PAY_BYTES)) u_seq (
    .clk(clk), .rst(rst),
    .setup_valid(setup_valid), .setup_ready(setup_ready),
    .kind_in(kind_w), .need_in(need_w),
    .wdat_valid(wdat_valid), .wdat_ready(wdat_ready), .wdat_byte(wdat_byte),
    .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_data(ev_data)
  );

  vreq_regs #(.PAY_BYTES(PAY_BYTES), .REF_RATE(REF_RATE), .RESET_BAUD(RESET_BAUD)) u_regs (
    .clk(clk), .rst(rst),
    .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_data(ev_data), .msr_in(msr_in),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .msr_rd_stb(msr_rd_stb), .wr_stb_q(reg_wr_stb),
    .lcr_q(lcr_q), .mcr_q(mcr_q), .div_q(div_q), .cts_gate_q(cts_gate_q)
  );

  p_ready_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(setup_ready && wdat_ready));
endmodule

// File: tb/vreq_decoder_bench.sv
module vreq_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        setup_valid = 1'b0;
  logic        setup_ready;
  logic [7:0]  setup_type = '0;
  logic [7:0]  setup_code = '0;
  logic [15:0] setup_len = '0;
  logic        wdat_valid = 1'b0;
  logic        wdat_ready;
  logic [7:0]  wdat_byte = '0;
  logic [7:0]  msr_in = '0;
  logic        rsp_valid, rsp_err, msr_rd_stb, cts_gate_q;
  logic [7:0]  rsp_data, lcr_q, mcr_q;
  logic [3:0]  reg_wr_stb;
  logic [31:0] div_q;

  int errors = 0;
  int checks = 0;
  logic [13:0] exp_q[$];
  logic [7:0]  m_lcr = 8'h00, m_mcr = 8'h00;
  logic [31:0] m_div = 32'd12;
  logic        m_cts = 1'b0;

  always #4 clk = ~clk;

  vreq_decoder u_vreq_decoder (
    .clk(clk), .rst(rst), .setup_valid(setup_valid), .setup_ready(setup_ready),
    .setup_type(setup_type), .setup_code(setup_code), .setup_len(setup_len),
    .wdat_valid(wdat_valid), .wdat_ready(wdat_ready), .wdat_byte(wdat_byte),
    .msr_in(msr_in), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .msr_rd_stb(msr_rd_stb), .reg_wr_stb(reg_wr_stb), .lcr_q(lcr_q), .mcr_q(mcr_q),
    .div_q(div_q), .cts_gate_q(cts_gate_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: response = {err, data, strobes, msr_strobe}
  always @(negedge clk) begin
    if (!rst) begin
      if (rsp_valid) begin
        if (exp_q.size() == 0) chk("R10 unexpected response", 32'd1, 32'd0);
        else chk("R10 response item", {18'd0, rsp_err, rsp_data, reg_wr_stb, msr_rd_stb},
                 {18'd0, exp_q.pop_front()});
      end else if (reg_wr_stb != 4'd0 || msr_rd_stb) begin
        chk("R10 strobe without response", {27'd0, reg_wr_stb, msr_rd_stb}, 32'd0);
      end
    end
  end

  task automatic expect_rsp(input logic err, input logic [7:0] d, input logic [3:0] s, input logic m);
    exp_q.push_back({err, d, s, m});
  endtask

  task automatic send_setup(input logic [7:0] t, input logic [7:0] c, input logic [15:0] l);
    @(negedge clk);
    wdat_valid = 1'b0;
    setup_type = t; setup_code = c; setup_len = l; setup_valid = 1'b1;
    while (!setup_ready) @(negedge clk);
  endtask

  task automatic put_byte(input logic [7:0] b, input int gap);
    @(negedge clk);
    setup_valid = 1'b0; wdat_valid = 1'b0;
    for (int i = 0; i < gap; i++) @(negedge clk);
    wdat_byte = b; wdat_valid = 1'b1;
    while (!wdat_ready) @(negedge clk);
  endtask

  task automatic settle();
    @(negedge clk);
    setup_valid = 1'b0; wdat_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_regs(input string req);
    chk({req, " lcr"}, {24'd0, lcr_q}, {24'd0, m_lcr});
    chk({req, " mcr"}, {24'd0, mcr_q}, {24'd0, m_mcr});
    chk({req, " div"}, div_q, m_div);
    chk({req, " cts"}, {31'd0, cts_gate_q}, {31'd0, m_cts});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check_regs("R1");
    chk("R1 setup_ready", {31'd0, setup_ready}, 32'd1);
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);

    // R2 line control write
    m_lcr = 8'h1B; expect_rsp(1'b0, 8'h00, 4'b0001, 1'b0);
    send_setup(8'h40, 8'd7, 16'd1); put_byte(8'h1B, 0); settle();
    check_regs("R2");

    // R3 line control read (no payload)
    expect_rsp(1'b0, 8'h1B, 4'b0000, 1'b0);
    send_setup(8'hC0, 8'd6, 16'd1); settle();

    // R4 modem control write
    m_mcr = 8'h0B; expect_rsp(1'b0, 8'h00, 4'b0010, 1'b0);
    send_setup(8'h40, 8'd10, 16'd1); put_byte(8'h0B, 1); settle();
    check_regs("R4");

    // R5 modem status read
    msr_in = 8'hA5; expect_rsp(1'b0, 8'hA5, 4'b0000, 1'b1);
    send_setup(8'hC0, 8'd2, 16'd1); settle();

    // R6 + R11 divisor, little-endian, with gaps, committed on fourth byte
    expect_rsp(1'b0, 8'h00, 4'b0100, 1'b0);
    send_setup(8'h40, 8'd5, 16'd4);
    put_byte(8'h78, 2); put_byte(8'h56, 0); put_byte(8'h34, 3);
    @(negedge clk); wdat_valid = 1'b0;
    @(negedge clk);
    chk("R6 divisor held before fourth byte", div_q, 32'd12);
    chk("R11 wdat_ready during gap", {31'd0, wdat_ready}, 32'd1);
    put_byte(8'h12, 1); settle();
    m_div = 32'h12345678;
    check_regs("R6");

    // R7 CTS gating set, clear, illegal value
    m_cts = 1'b1; expect_rsp(1'b0, 8'h00, 4'b1000, 1'b0);
    send_setup(8'h40, 8'd12, 16'd1); put_byte(8'h01, 0); settle();
    check_regs("R7 set");
    expect_rsp(1'b1, 8'h00, 4'b0000, 1'b0);
    send_setup(8'h40, 8'd12, 16'd1); put_byte(8'h05, 0); settle();
    check_regs("R7 illegal");
    m_cts = 1'b0; expect_rsp(1'b0, 8'h00, 4'b1000, 1'b0);
    send_setup(8'h40, 8'd12, 16'd1); put_byte(8'h00, 0); settle();
    check_regs("R7 clear");

    // R8 no-effect request
    expect_rsp(1'b0, 8'h00, 4'b0000, 1'b0);
    send_setup(8'h40, 8'd11, 16'd1); put_byte(8'h00, 0); settle();
    check_regs("R8");

    // R9 rejected requests: unknown code, wrong direction, wrong length
    expect_rsp(1'b1, 8'h00, 4'b0000, 1'b0);
    send_setup(8'h40, 8'd3, 16'd1);
    @(negedge clk); setup_valid = 1'b0; wdat_valid = 1'b1; wdat_byte = 8'hEE;
    chk("R9 no payload accepted", {31'd0, wdat_ready}, 32'd0);
    @(negedge clk);
    chk("R9 still ready for setup", {31'd0, setup_ready}, 32'd1);
    wdat_valid = 1'b0;
    expect_rsp(1'b1, 8'h00, 4'b0000, 1'b0);
    send_setup(8'hC0, 8'd7, 16'd1); settle();
    expect_rsp(1'b1, 8'h00, 4'b0000, 1'b0);
    send_setup(8'h40, 8'd7, 16'd2); settle();
    expect_rsp(1'b1, 8'h00, 4'b0000, 1'b0);
    send_setup(8'h40, 8'd5, 16'd1); settle();
    expect_rsp(1'b1, 8'h00, 4'b0000, 1'b0);
    send_setup(8'h21, 8'd6, 16'd1); settle();
    check_regs("R9");

    // R10 back-to-back reads, one response each
    msr_in = 8'h3C;
    expect_rsp(1'b0, 8'h1B, 4'b0000, 1'b0);
    expect_rsp(1'b0, 8'h3C, 4'b0000, 1'b1);
    send_setup(8'hC0, 8'd6, 16'd1);
    send_setup(8'hC0, 8'd2, 16'd1);
    settle();
    chk("R10 all responses seen", exp_q.size(), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule